// File: doc/BRIEF.md
# Register-write command list engine

This block lets a processor hand off a batch of register programming to hardware. Software builds a list of entries in memory, one entry per register write. Each entry is a data value plus a control word that holds a target register offset and two flags. Software then writes the list address and a run bit into the task input. The engine reads the list one entry at a time through a simple read port. It replays each valid entry as a write on a register-bus master port, and it stops when it meets an entry flagged as the last one.

Both bus ports use a request/acknowledge handshake. A request stays asserted, with its address and data steady, until the acknowledge arrives in a sampled cycle. The engine does not start fetching the next entry until the current write has been acknowledged. A status word reports whether the engine is running, whether the list ended normally, and whether it stopped on a malformed entry. Software can clear that status.

Top module: `regCmdEngine`

## Requirements
- R1: A task write taken while idle, with bit 0 set, starts the engine. Busy is seen from the next cycle, and the first fetch uses the address formed from task bits 31..7 followed by seven zero bits. Task bits 6..0 play no part in the address.
- R2: A task write with bit 0 clear does not start the engine. No fetch is issued and busy stays low.
- R3: Each entry is two 32-bit words. The value word is read at the entry address and the control word at entry address + 4. Entries follow each other at 8-byte steps. A fetch request holds its address until the acknowledge arrives.
- R4: An entry whose control bit 31 (valid) is set produces exactly one register write. The write carries the value word to offset control[19:2] followed by two zero bits. The write request holds address and data until acknowledged, and no fetch starts before that acknowledge.
- R5: A valid entry that also has control bit 30 (terminate) set performs its write. After the acknowledge the engine goes idle with the end flag set.
- R6: An entry with bit 31 clear and bit 30 set makes no write. It sets the end flag and returns the engine to idle.
- R7: An entry with both bit 31 and bit 30 clear makes no write. It sets the error flag and returns the engine to idle.
- R8: Any task write taken while busy is ignored: it does not redirect the list, restart it, or clear the error flag.
- R9: A task write taken while idle with bit 3 set clears the error flag.
- R10: A pulse on the status-clear input clears the end and error flags.
- R11: Status word layout: bit 0 busy, bit 2 end, bit 3 error, all other bits zero. The status word is zero after reset.
- R12: Starting a list clears the end flag. The error flag is kept unless bit 3 of the same task write is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| taskWr | input | 1 | Task register write strobe |
| taskData | input | 32 | Task word: [31:7] list address, [3] error clear, [0] run |
| statClr | input | 1 | Clears end and error status flags |
| statusWord | output | 32 | [0] busy, [2] end, [3] error |
| memReq | output | 1 | List read request |
| memAddr | output | 32 | List read byte address |
| memAck | input | 1 | Read acknowledge; memRdata valid with it |
| memRdata | input | 32 | Read data |
| regReq | output | 1 | Register write request |
| regAddr | output | 20 | Register byte offset, bits 1..0 zero |
| regWdata | output | 32 | Register write value |
| regAck | input | 1 | Register write acknowledge |

## Verification
The hardest case to reach from the ports is a task write that arrives while a list is mid-flight, together with an error flag already latched from an earlier list. The bench gets there in two steps. First it runs a list that ends on a malformed entry. Next it starts a longer list without clearing the error, and one cycle later it issues a competing task write that carries both the run bit and the error-clear bit. Acknowledges on both ports come from a pseudo-random pattern, so requests are held across varying stalls. A behavioural model checks every output on every cycle, and a queue of expected writes checks the final order of writes.

// File: rtl/regCmdPkg.sv
package regCmdPkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WORD0 = 2'd1,
    ST_WORD1 = 2'd2,
    ST_WRITE = 2'd3
  } seqState_e;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic start;    // load list base, raise busy, drop end
    logic clrErr;   // idle task write with error-clear bit
    logic capVal;   // latch value word
    logic capCtl;   // latch offset and terminate flag
    logic advance;  // step to next entry
    logic finEnd;   // list ended normally
    logic finErr;   // list ended on malformed entry
  } seqStrobe_t;

  localparam int TASK_RUN_BIT  = 0;
  localparam int TASK_CLR_BIT  = 3;
  localparam int STAT_BUSY_BIT = 0;
  localparam int STAT_END_BIT  = 2;
  localparam int STAT_ERR_BIT  = 3;

endpackage

// File: rtl/regCmdCtrl.sv
module regCmdCtrl
  import regCmdPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       taskWr,
  input  logic       taskRun,
  input  logic       taskErrClr,
  input  logic       memAck,
  input  logic       fetchValid,
  input  logic       fetchTerm,
  input  logic       regAck,
  input  logic       entryTerm,
  output logic       memReq,
  output logic       wordSel,
  output logic       regReq,
  output seqStrobe_t strb
);

  seqState_e state, stateNx;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  always_comb begin
    stateNx = state;
    strb    = '0;
    unique case (state)
      ST_IDLE: begin
        strb.clrErr = taskWr & taskErrClr;
        if (taskWr && taskRun) begin
          strb.start = 1'b1;
          stateNx    = ST_WORD0;
        end
      end
      ST_WORD0: begin
        if (memAck) begin
          strb.capVal = 1'b1;
          stateNx     = ST_WORD1;
        end
      end
      ST_WORD1: begin
        if (memAck) begin
          if (fetchValid) begin
            strb.capCtl = 1'b1;
            stateNx     = ST_WRITE;
          end else if (fetchTerm) begin
            strb.finEnd = 1'b1;
            stateNx     = ST_IDLE;
          end else begin
            strb.finErr = 1'b1;
            stateNx     = ST_IDLE;
          end
        end
      end
      ST_WRITE: begin
        if (regAck) begin
          if (entryTerm) begin
            strb.finEnd = 1'b1;
            stateNx     = ST_IDLE;
          end else begin
            strb.advance = 1'b1;
            stateNx      = ST_WORD0;
          end
        end
      end
      default: stateNx = ST_IDLE;
    endcase
  end

  assign memReq  = (state == ST_WORD0) || (state == ST_WORD1);
  assign wordSel = (state == ST_WORD1);
  assign regReq  = (state == ST_WRITE);

  // R3: an unacknowledged fetch stays on the same word
  assert_fetch_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memAck) |=> (memReq && wordSel == $past(wordSel)));

  // R4: an unacknowledged write stays pending, no fetch meanwhile
  assert_write_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> (regReq && !memReq));

endmodule

// File: rtl/regCmdPath.sv
module regCmdPath
  import regCmdPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 20,
  parameter int ALIGN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [DATA_W-1:0] taskData,
  input  logic [DATA_W-1:0] memRdata,
  input  logic              statClr,
  input  logic              wordSel,
  output logic [ADDR_W-1:0] memAddr,
  output logic [OFF_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  output logic              entryTerm,
  output logic              busy,
  output logic [DATA_W-1:0] statusWord
);

  localparam int WORD_SH  = $clog2(DATA_W / 8);
  localparam int ENTRY_SH = WORD_SH + 1;
  localparam int PTR_W    = ADDR_W - ENTRY_SH;
  localparam int PAD_W    = ALIGN_W - ENTRY_SH;
  localparam int OFFR_W   = OFF_W - WORD_SH;
  localparam int TERM_BIT = DATA_W - 2;

  logic [PTR_W-1:0]  entryPtr;
  logic [DATA_W-1:0] valueReg;
  logic [OFFR_W-1:0] offsetReg;
  logic              termReg;
  logic              busyFlag, endFlag, errFlag;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entryPtr <= '0;
    end else if (strb.start) begin
      entryPtr <= {taskData[ADDR_W-1:ALIGN_W], {PAD_W{1'b0}}};
    end else if (strb.advance) begin
      entryPtr <= entryPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      valueReg  <= '0;
      offsetReg <= '0;
      termReg   <= 1'b0;
    end else begin
      if (strb.capVal) valueReg <= memRdata;
      if (strb.capCtl) begin
        offsetReg <= memRdata[OFF_W-1:WORD_SH];
        termReg   <= memRdata[TERM_BIT];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyFlag <= 1'b0;
      endFlag  <= 1'b0;
      errFlag  <= 1'b0;
    end else begin
      if (strb.start)                     busyFlag <= 1'b1;
      else if (strb.finEnd || strb.finErr) busyFlag <= 1'b0;

      if (strb.finEnd)                    endFlag <= 1'b1;
      else if (strb.start || statClr)     endFlag <= 1'b0;

      if (strb.finErr)                    errFlag <= 1'b1;
      else if (strb.clrErr || statClr)    errFlag <= 1'b0;
    end
  end

  assign memAddr   = {entryPtr, wordSel, {WORD_SH{1'b0}}};
  assign regAddr   = {offsetReg, {WORD_SH{1'b0}}};
  assign regWdata  = valueReg;
  assign entryTerm = termReg;
  assign busy      = busyFlag;

  always_comb begin
    statusWord                = '0;
    statusWord[STAT_BUSY_BIT] = busyFlag;
    statusWord[STAT_END_BIT]  = endFlag;
    statusWord[STAT_ERR_BIT]  = errFlag;
  end

  logic unusedTaskBits;
  assign unusedTaskBits = ^{taskData[ALIGN_W-1:0], memRdata[DATA_W-1], memRdata[DATA_W-3:OFF_W],
                            memRdata[WORD_SH-1:0]};

  // R7: error appears only as the engine drops to idle
  assert_err_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errFlag) |-> !busyFlag);

  // R5: end appears only as the engine drops to idle
  assert_end_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(endFlag) |-> !busyFlag);

  // R12: a start leaves the engine busy with end cleared
  assert_start_clears_end_R12: assert property (@(posedge clk) disable iff (!rstN)
    strb.start |=> (busyFlag && !endFlag));

endmodule

// File: rtl/regCmdEngine.sv
module regCmdEngine
  import regCmdPkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int OFF_W   = 20,
  parameter int ALIGN_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              taskWr,
  input  logic [DATA_W-1:0] taskData,
  input  logic              statClr,
  output logic [DATA_W-1:0] statusWord,
  output logic              memReq,
  output logic [ADDR_W-1:0] memAddr,
  input  logic              memAck,
  input  logic [DATA_W-1:0] memRdata,
  output logic              regReq,
  output logic [OFF_W-1:0]  regAddr,
  output logic [DATA_W-1:0] regWdata,
  input  logic              regAck
);

  localparam int VALID_BIT = DATA_W - 1;
  localparam int TERM_BIT  = DATA_W - 2;

  seqStrobe_t strb;
  logic       wordSel;
  logic       entryTerm;
  logic       busy;

  regCmdCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .taskWr     (taskWr),
    .taskRun    (taskData[TASK_RUN_BIT]),
    .taskErrClr (taskData[TASK_CLR_BIT]),
    .memAck     (memAck),
    .fetchValid (memRdata[VALID_BIT]),
    .fetchTerm  (memRdata[TERM_BIT]),
    .regAck     (regAck),
    .entryTerm  (entryTerm),
    .memReq     (memReq),
    .wordSel    (wordSel),
    .regReq     (regReq),
    .strb       (strb)
  );

  regCmdPath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OFF_W   (OFF_W),
    .ALIGN_W (ALIGN_W)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .taskData   (taskData),
    .memRdata   (memRdata),
    .statClr    (statClr),
    .wordSel    (wordSel),
    .memAddr    (memAddr),
    .regAddr    (regAddr),
    .regWdata   (regWdata),
    .entryTerm  (entryTerm),
    .busy       (busy),
    .statusWord (statusWord)
  );

  // R4: pending write keeps offset and value steady
  assert_write_fields_R4: assert property (@(posedge clk) disable iff (!rstN)
    (regReq && !regAck) |=> ($stable(regAddr) && $stable(regWdata)));

  // R8: a task write while busy does not move the fetch address
  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && taskWr && memReq && !memAck) |=> $stable(memAddr));

endmodule

// File: tb/regCmdEngine_test.sv
module regCmdEngine_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        taskWr = 1'b0;
  logic [31:0] taskData = '0;
  logic        statClr = 1'b0;
  logic        memAck = 1'b0;
  logic [31:0] memRdata = '0;
  logic        regAck = 1'b0;
  logic [31:0] statusWord;
  logic        memReq;
  logic [31:0] memAddr;
  logic        regReq;
  logic [19:0] regAddr;
  logic [31:0] regWdata;

  always #4 clk = ~clk;

  regCmdEngine uut (
    .clk(clk), .rstN(rstN), .taskWr(taskWr), .taskData(taskData), .statClr(statClr),
    .statusWord(statusWord), .memReq(memReq), .memAddr(memAddr), .memAck(memAck),
    .memRdata(memRdata), .regReq(regReq), .regAddr(regAddr), .regWdata(regWdata),
    .regAck(regAck)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit finished = 0;

  logic [31:0] mem [0:1023];
  logic [15:0] lfsr = 16'hACE1;
  logic [51:0] expQ [$];

  // behavioural reference state
  int          mPhase = 0;
  logic [31:0] mPtr = '0, mVal = '0;
  logic [19:0] mOff = '0;
  logic        mTerm = 0, mEnd = 0, mErr = 0;

  localparam logic [31:0] VLD = 32'h8000_0000;
  localparam logic [31:0] TRM = 32'h4000_0000;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mEnd = 0; mErr = 0; mPtr = '0;
    end else begin
      if (statClr) begin mEnd = 0; mErr = 0; end
      case (mPhase)
        0: begin
          if (taskWr && taskData[3]) mErr = 0;
          if (taskWr && taskData[0]) begin
            mPtr = {taskData[31:7], 7'b0}; mEnd = 0; mPhase = 1;
          end
        end
        1: if (memAck) begin mVal = memRdata; mPhase = 2; end
        2: if (memAck) begin
          if (memRdata[31]) begin
            mOff = {memRdata[19:2], 2'b00}; mTerm = memRdata[30]; mPhase = 3;
          end else if (memRdata[30]) begin mEnd = 1; mPhase = 0; end
          else begin mErr = 1; mPhase = 0; end
        end
        3: if (regAck) begin
          if (mTerm) begin mEnd = 1; mPhase = 0; end
          else begin mPtr = mPtr + 8; mPhase = 1; end
        end
        default: mPhase = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN) begin
      chk(memReq == (mPhase == 1 || mPhase == 2), "R3 memReq", 64'(memReq), 64'(mPhase == 1 || mPhase == 2));
      if (memReq)
        chk(memAddr == mPtr + (mPhase == 2 ? 4 : 0), "R3 memAddr", 64'(memAddr), 64'(mPtr + (mPhase == 2 ? 4 : 0)));
      chk(regReq == (mPhase == 3), "R4 regReq", 64'(regReq), 64'(mPhase == 3));
      if (regReq) begin
        chk(regAddr == mOff, "R4 regAddr", 64'(regAddr), 64'(mOff));
        chk(regWdata == mVal, "R4 regWdata", 64'(regWdata), 64'(mVal));
      end
      chk(statusWord == {28'b0, mErr, mEnd, 1'b0, 1'(mPhase != 0)}, "R11 status",
          64'(statusWord), 64'({28'b0, mErr, mEnd, 1'b0, 1'(mPhase != 0)}));
    end
    lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    memAck   = memReq && (lfsr[1:0] != 2'b00);
    memRdata = mem[memAddr[11:2]];
    regAck   = regReq && (lfsr[5:4] == 2'b11 || lfsr[7]);
    if (rstN && regReq && regAck) begin
      if (expQ.size() == 0) chk(0, "R6 R7 unexpected write", 64'(regAddr), 64'hFFFF);
      else begin
        logic [51:0] e;
        e = expQ.pop_front();
        chk({regAddr, regWdata} == e, "R4 write order", 64'({regAddr, regWdata}), 64'(e));
      end
    end
    if (cycles > 150000) begin
      chk(0, "watchdog", 64'(cycles), 64'd150000);
      summary();
    end
  end

  task automatic putEntry(input int base, input int idx, input logic [31:0] val, input logic [31:0] ctl);
    mem[(base >> 2) + 2 * idx]     = val;
    mem[(base >> 2) + 2 * idx + 1] = ctl;
  endtask

  task automatic taskWrite(input logic [31:0] d);
    @(negedge clk); taskWr = 1; taskData = d;
    @(negedge clk); taskWr = 0; taskData = '0;
  endtask

  task automatic waitIdle(input string tag);
    int n = 0;
    while (statusWord[0] && n < 4000) begin @(negedge clk); n++; end
    if (n >= 4000) chk(0, tag, 64'(statusWord), 64'd0);
    @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(statusWord == 0, "R11 reset status", 64'(statusWord), 0);
    chk(!memReq && !regReq, "R11 reset idle", 64'({memReq, regReq}), 0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // list A: three writes, last one terminating, unaligned task address bits
    putEntry(32'h100, 0, 32'h1111_1111, VLD | 32'h0_0404);
    putEntry(32'h100, 1, 32'h2222_2222, VLD | 32'h0_ABC7);
    putEntry(32'h100, 2, 32'h3333_3333, VLD | TRM | 32'h1_2340);
    expQ.push_back({20'h00404, 32'h1111_1111});
    expQ.push_back({20'h0ABC4, 32'h2222_2222});
    expQ.push_back({20'h12340, 32'h3333_3333});
    taskWrite(32'h0000_0177);
    chk(memReq && memAddr == 32'h100, "R1 first fetch aligned", 64'(memAddr), 64'h100);
    chk(statusWord[0] == 1, "R1 busy after start", 64'(statusWord), 1);
    waitIdle("R5 list A hang");
    chk(statusWord == 32'h4, "R5 end after terminating write", 64'(statusWord), 4);
    chk(expQ.size() == 0, "R4 all writes of A", 64'(expQ.size()), 0);

    // list B: two writes then non-valid terminator
    putEntry(32'h200, 0, 32'hA5A5_0001, VLD | 32'h0_0010);
    putEntry(32'h200, 1, 32'hA5A5_0002, VLD | 32'h0_0014);
    putEntry(32'h200, 2, 32'hDEAD_BEEF, TRM | 32'h0_0018);
    expQ.push_back({20'h00010, 32'hA5A5_0001});
    expQ.push_back({20'h00014, 32'hA5A5_0002});
    taskWrite(32'h0000_0201);
    chk(statusWord[2] == 0, "R12 start clears end", 64'(statusWord), 1);
    waitIdle("R6 list B hang");
    chk(statusWord == 32'h4, "R6 end without write", 64'(statusWord), 4);
    chk(expQ.size() == 0, "R6 writes of B", 64'(expQ.size()), 0);

    // list C: malformed second entry
    putEntry(32'h300, 0, 32'h0BAD_0001, VLD | 32'h0_0100);
    putEntry(32'h300, 1, 32'hFFFF_FFFF, 32'h0_0104);
    expQ.push_back({20'h00100, 32'h0BAD_0001});
    taskWrite(32'h0000_0301);
    waitIdle("R7 list C hang");
    chk(statusWord == 32'h8, "R7 error stop", 64'(statusWord), 8);
    chk(expQ.size() == 0, "R7 writes of C", 64'(expQ.size()), 0);

    // list D while error latched, with an ignored task write mid-run
    for (int i = 0; i < 4; i++)
      putEntry(32'h400, i, 32'hD000_0000 + i, (i == 3 ? (VLD | TRM) : VLD) | (32'h0_2000 + 4 * i));
    for (int i = 0; i < 4; i++) expQ.push_back({20'h02000 + 20'(4 * i), 32'hD000_0000 + i});
    taskWrite(32'h0000_0401);
    chk(statusWord[3] == 1, "R12 start keeps error", 64'(statusWord), 8);
    taskWrite(32'h0000_0309);
    chk(statusWord[3] == 1 && statusWord[0] == 1, "R8 busy write ignored", 64'(statusWord), 9);
    waitIdle("R8 list D hang");
    chk(statusWord == 32'hC, "R8 error kept, end set", 64'(statusWord), 32'hC);
    chk(expQ.size() == 0, "R8 writes of D", 64'(expQ.size()), 0);

    // error clear by task bit 3, no run
    taskWrite(32'h0000_0008);
    chk(statusWord == 32'h4, "R9 error cleared", 64'(statusWord), 4);

    // run bit clear: no start
    taskWrite(32'h0000_0500);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 9) chk(!memReq && statusWord[0] == 0, "R2 no start", 64'({memReq, statusWord[0]}), 0);
    end

    // status clear
    @(negedge clk); statClr = 1;
    @(negedge clk); statClr = 0;
    chk(statusWord == 0, "R10 status cleared", 64'(statusWord), 0);

    // error then status clear
    putEntry(32'h500, 0, 32'h0, 32'h0);
    taskWrite(32'h0000_0501);
    waitIdle("R7 list E hang");
    chk(statusWord == 32'h8, "R7 immediate error", 64'(statusWord), 8);
    @(negedge clk); statClr = 1;
    @(negedge clk); statClr = 0;
    chk(statusWord == 0, "R10 error cleared by status clear", 64'(statusWord), 0);

    repeat (5) @(negedge clk);
    summary();
  end

endmodule